// File: doc/BRIEF.md
# Sleep-Mode Peripheral Enable Controller

This block decides, for every clock, which on-chip support circuits stay powered. While the chip is awake every enable simply follows its software or fuse control. When a sleep request is raised, a 3-bit mode selector picks how deep the chip goes. From that depth the block derives which clock domains keep running. It then gates the analog comparator, the ADC's reference request, the main clock and the digital input buffers to match.

The enables are linked to one another. The voltage reference is a shared resource that stays on while any of its consumers asks for it. A comparator that has been switched to the internal reference keeps the reference alive in every mode, even where the comparator itself is turned off. Debug configuration can hold the main clock on in the two deepest modes. Pins flagged in a wake mask keep their input buffers so that wake-up logic elsewhere can see them. All outputs come from registers.

Top module: `slp_pwr_ctl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs read: comparator, brown-out, reference, watchdog and JTAG enables 0; main clock enable 1; all input buffer enables 1.
- R2: Mode codes are 000 Idle, 001 ADC Noise Reduction, 010 Power-down, 011 Power-save, 110 Standby, 111 Extended Standby. Codes 100 and 101 behave exactly like Idle.
- R3: During sleep, `acmp_en` equals `sw_acmp_en` in Idle and ADC Noise Reduction, and is 0 in every other mode.
- R4: `vref_en` is the OR of three requests. The brown-out request is `fuse_bod_en`. The comparator request is `sw_acmp_en & acmp_use_ref`. The ADC request is `sw_adc_en` while awake, and during sleep it counts only in Idle and ADC Noise Reduction.
- R5: A comparator that is enabled and selects the internal reference keeps `vref_en` at 1 in every sleep mode, including modes where `acmp_en` is forced to 0.
- R6: `bod_en` equals `fuse_bod_en` in every state, awake or asleep.
- R7: `wdt_en` equals `sw_wdt_en` in every state, awake or asleep.
- R8: During sleep in Power-down, Power-save, Standby and Extended Standby, bit i of `inbuf_en` equals bit i of `wake_pin_mask`. In Idle and ADC Noise Reduction all bits are 1.
- R9: During sleep in Power-down or Power-save, `main_clk_en` is 1 only when `fuse_ocd_en` is 1 and the JTAG interface is active. In all other sleep modes it is 1.
- R10: `jtag_en` is `fuse_jtag_en & ~sw_jtag_off` in every state.
- R11: Each output reflects the inputs sampled at the previous rising clock edge. A change to sleep request or mode shows up exactly one clock later, and never earlier.
- R12: While `sleep_req` is 0, `acmp_en` follows `sw_acmp_en`, `main_clk_en` is 1 and every `inbuf_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | 1 = chip is asleep in the selected mode |
| sleep_mode | input | 3 | Encoded sleep depth (see R2) |
| fuse_bod_en | input | 1 | Brown-out detector fuse |
| fuse_ocd_en | input | 1 | On-chip debug fuse |
| fuse_jtag_en | input | 1 | JTAG interface fuse |
| sw_jtag_off | input | 1 | Software JTAG disable |
| sw_acmp_en | input | 1 | Software comparator enable |
| sw_adc_en | input | 1 | Software ADC enable |
| sw_wdt_en | input | 1 | Software watchdog enable |
| acmp_use_ref | input | 1 | Comparator selects internal reference |
| wake_pin_mask | input | NUM_PINS | Pins whose buffers stay on in deep sleep |
| acmp_en | output | 1 | Comparator enable |
| bod_en | output | 1 | Brown-out detector enable |
| vref_en | output | 1 | Internal voltage reference enable |
| wdt_en | output | 1 | Watchdog enable |
| main_clk_en | output | 1 | Main clock source enable |
| jtag_en | output | 1 | JTAG interface enable |
| inbuf_en | output | NUM_PINS | Per-pin digital input buffer enable |

## Verification
The bench builds the block with NUM_PINS set to 12, a width that is not a power of two. With that width, a mask bit landing in the wrong lane, or a top bit left out of the generate loop, shows up as a mismatch. First a directed sweep walks all eight mode codes, awake and asleep, with every fuse and enable pattern. A long pseudo-random run then follows, in which the mode code changes on consecutive clocks. This lets a reference model check the one-clock latency and the cross-coupled reference request against live mode transitions.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        SM_IDLE  = 3'b000,
        SM_ADCNR = 3'b001,
        SM_PDOWN = 3'b010,
        SM_PSAVE = 3'b011,
        SM_STBY  = 3'b110,
        SM_XSTBY = 3'b111
    } slp_mode_e;

    // Which clock domains keep running in the current state.
    typedef struct packed {
        logic io_clk;
        logic adc_clk;
        logic osc_stop;   // main oscillator would normally stop
    } clk_dom_t;

    // Scalar enables produced by the controller.
    typedef struct packed {
        logic acmp;
        logic bod;
        logic vref;
        logic wdt;
        logic main_clk;
        logic jtag;
    } en_vec_t;

    localparam en_vec_t EN_RESET = '{acmp: 1'b0, bod: 1'b0, vref: 1'b0,
                                     wdt: 1'b0, main_clk: 1'b1, jtag: 1'b0};

    // Unused codes fold onto Idle.
    function automatic slp_mode_e norm_mode(input logic [2:0] code);
        case (code)
            3'b001:  return SM_ADCNR;
            3'b010:  return SM_PDOWN;
            3'b011:  return SM_PSAVE;
            3'b110:  return SM_STBY;
            3'b111:  return SM_XSTBY;
            default: return SM_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
    import slp_pkg::*;
(
    input  logic       sleep_req,
    input  logic [2:0] sleep_mode,
    output clk_dom_t   dom
);
    slp_mode_e mode;

    always_comb begin
        mode = norm_mode(sleep_mode);
        dom  = '{io_clk: 1'b1, adc_clk: 1'b1, osc_stop: 1'b0};
        if (sleep_req) begin
            case (mode)
                SM_IDLE:  dom = '{io_clk: 1'b1, adc_clk: 1'b1, osc_stop: 1'b0};
                SM_ADCNR: dom = '{io_clk: 1'b0, adc_clk: 1'b1, osc_stop: 1'b0};
                SM_PDOWN,
                SM_PSAVE: dom = '{io_clk: 1'b0, adc_clk: 1'b0, osc_stop: 1'b1};
                default:  dom = '{io_clk: 1'b0, adc_clk: 1'b0, osc_stop: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/slp_enable_logic.sv
module slp_enable_logic
    import slp_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  clk_dom_t            dom,
    input  logic                fuse_bod_en,
    input  logic                fuse_ocd_en,
    input  logic                fuse_jtag_en,
    input  logic                sw_jtag_off,
    input  logic                sw_acmp_en,
    input  logic                sw_adc_en,
    input  logic                sw_wdt_en,
    input  logic                acmp_use_ref,
    input  logic [NUM_PINS-1:0] wake_pin_mask,
    output en_vec_t             en_nxt,
    output logic [NUM_PINS-1:0] inbuf_nxt
);
    logic jtag_live;
    logic ref_by_cmp;
    logic ref_by_adc;
    logic buf_all_on;

    always_comb begin
        jtag_live       = fuse_jtag_en & ~sw_jtag_off;
        ref_by_cmp      = sw_acmp_en & acmp_use_ref;
        ref_by_adc      = sw_adc_en & dom.adc_clk;
        en_nxt.acmp     = sw_acmp_en & dom.adc_clk;
        en_nxt.bod      = fuse_bod_en;
        en_nxt.vref     = fuse_bod_en | ref_by_cmp | ref_by_adc;
        en_nxt.wdt      = sw_wdt_en;
        en_nxt.jtag     = jtag_live;
        en_nxt.main_clk = ~dom.osc_stop | (fuse_ocd_en & jtag_live);
        buf_all_on      = dom.io_clk | dom.adc_clk;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign inbuf_nxt[p] = buf_all_on | wake_pin_mask[p];
    end
endmodule

// File: rtl/slp_out_reg.sv
module slp_out_reg
    import slp_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  en_vec_t             en_nxt,
    input  logic [NUM_PINS-1:0] inbuf_nxt,
    output en_vec_t             en_q,
    output logic [NUM_PINS-1:0] inbuf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= EN_RESET;
            inbuf_q <= '1;
        end else begin
            en_q    <= en_nxt;
            inbuf_q <= inbuf_nxt;
        end
    end
endmodule

// File: rtl/slp_pwr_ctl.sv
module slp_pwr_ctl
    import slp_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_req,
    input  logic [2:0]          sleep_mode,
    input  logic                fuse_bod_en,
    input  logic                fuse_ocd_en,
    input  logic                fuse_jtag_en,
    input  logic                sw_jtag_off,
    input  logic                sw_acmp_en,
    input  logic                sw_adc_en,
    input  logic                sw_wdt_en,
    input  logic                acmp_use_ref,
    input  logic [NUM_PINS-1:0] wake_pin_mask,
    output logic                acmp_en,
    output logic                bod_en,
    output logic                vref_en,
    output logic                wdt_en,
    output logic                main_clk_en,
    output logic                jtag_en,
    output logic [NUM_PINS-1:0] inbuf_en
);
    clk_dom_t            dom;
    en_vec_t             en_nxt;
    en_vec_t             en_q;
    logic [NUM_PINS-1:0] inbuf_nxt;

    slp_mode_decode u_dec (
        .sleep_req  (sleep_req),
        .sleep_mode (sleep_mode),
        .dom        (dom)
    );

    slp_enable_logic #(.NUM_PINS(NUM_PINS)) u_logic (
        .dom           (dom),
        .fuse_bod_en   (fuse_bod_en),
        .fuse_ocd_en   (fuse_ocd_en),
        .fuse_jtag_en  (fuse_jtag_en),
        .sw_jtag_off   (sw_jtag_off),
        .sw_acmp_en    (sw_acmp_en),
        .sw_adc_en     (sw_adc_en),
        .sw_wdt_en     (sw_wdt_en),
        .acmp_use_ref  (acmp_use_ref),
        .wake_pin_mask (wake_pin_mask),
        .en_nxt        (en_nxt),
        .inbuf_nxt     (inbuf_nxt)
    );

    slp_out_reg #(.NUM_PINS(NUM_PINS)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .en_nxt    (en_nxt),
        .inbuf_nxt (inbuf_nxt),
        .en_q      (en_q),
        .inbuf_q   (inbuf_en)
    );

    assign acmp_en     = en_q.acmp;
    assign bod_en      = en_q.bod;
    assign vref_en     = en_q.vref;
    assign wdt_en      = en_q.wdt;
    assign main_clk_en = en_q.main_clk;
    assign jtag_en     = en_q.jtag;
endmodule

// File: rtl/slp_pwr_ctl_chk.sv
module slp_pwr_ctl_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                sleep_req,
    input logic [2:0]          sleep_mode,
    input logic                fuse_bod_en,
    input logic                fuse_ocd_en,
    input logic                fuse_jtag_en,
    input logic                sw_jtag_off,
    input logic                sw_acmp_en,
    input logic                sw_wdt_en,
    input logic                acmp_use_ref,
    input logic                acmp_en,
    input logic                bod_en,
    input logic                vref_en,
    input logic                wdt_en,
    input logic                main_clk_en,
    input logic                jtag_en,
    input logic [NUM_PINS-1:0] inbuf_en
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    logic deep_osc;
    logic cmp_off_mode;
    assign deep_osc     = sleep_req && (sleep_mode == 3'b010 || sleep_mode == 3'b011);
    assign cmp_off_mode = sleep_req && (sleep_mode == 3'b010 || sleep_mode == 3'b011 ||
                                        sleep_mode == 3'b110 || sleep_mode == 3'b111);

    // R3
    cmp_forced_off_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(cmp_off_mode) |-> !acmp_en);

    // R5
    cmp_ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(sw_acmp_en && acmp_use_ref) |-> vref_en);

    // R4
    bod_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
        bod_en |-> vref_en);

    // R6
    bod_follow_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> bod_en == $past(fuse_bod_en));

    // R7
    wdt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> wdt_en == $past(sw_wdt_en));

    // R9
    mclk_stop_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(deep_osc && !fuse_ocd_en) |-> !main_clk_en);

    // R10
    jtag_gate_chk: assert property (@(posedge clk) disable iff (rst)
        jtag_en |-> past_ok && $past(fuse_jtag_en && !sw_jtag_off));

    // R12
    awake_bufs_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(!sleep_req) |-> (&inbuf_en) && main_clk_en);
endmodule

bind slp_pwr_ctl slp_pwr_ctl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sleep_req    (sleep_req),
    .sleep_mode   (sleep_mode),
    .fuse_bod_en  (fuse_bod_en),
    .fuse_ocd_en  (fuse_ocd_en),
    .fuse_jtag_en (fuse_jtag_en),
    .sw_jtag_off  (sw_jtag_off),
    .sw_acmp_en   (sw_acmp_en),
    .sw_wdt_en    (sw_wdt_en),
    .acmp_use_ref (acmp_use_ref),
    .acmp_en      (acmp_en),
    .bod_en       (bod_en),
    .vref_en      (vref_en),
    .wdt_en       (wdt_en),
    .main_clk_en  (main_clk_en),
    .jtag_en      (jtag_en),
    .inbuf_en     (inbuf_en)
);

// File: tb/slp_pwr_ctl_tb_top.sv
module slp_pwr_ctl_tb_top;
    localparam int NP = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 0;
    logic [2:0] sleep_mode = 0;
    logic fuse_bod_en = 0, fuse_ocd_en = 0, fuse_jtag_en = 0, sw_jtag_off = 0;
    logic sw_acmp_en = 0, sw_adc_en = 0, sw_wdt_en = 0, acmp_use_ref = 0;
    logic [NP-1:0] wake_pin_mask = '0;
    logic acmp_en, bod_en, vref_en, wdt_en, main_clk_en, jtag_en;
    logic [NP-1:0] inbuf_en;

    always #2 clk = ~clk;   // 250 MHz

    slp_pwr_ctl #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .fuse_bod_en(fuse_bod_en), .fuse_ocd_en(fuse_ocd_en),
        .fuse_jtag_en(fuse_jtag_en), .sw_jtag_off(sw_jtag_off),
        .sw_acmp_en(sw_acmp_en), .sw_adc_en(sw_adc_en), .sw_wdt_en(sw_wdt_en),
        .acmp_use_ref(acmp_use_ref), .wake_pin_mask(wake_pin_mask),
        .acmp_en(acmp_en), .bod_en(bod_en), .vref_en(vref_en), .wdt_en(wdt_en),
        .main_clk_en(main_clk_en), .jtag_en(jtag_en), .inbuf_en(inbuf_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // expected values for the next sample, with the tags they belong to
    logic e_acmp, e_bod, e_vref, e_wdt, e_mclk, e_jtag;
    logic [NP-1:0] e_buf;
    string t_acmp, t_vref, t_mclk, t_buf;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Behavioural model of the requirements.
    task automatic predict();
        int code;
        bit idle_like, adc_like, deep, live_jtag;
        code = int'(sleep_mode);
        idle_like = (code == 0) || (code == 4) || (code == 5);
        adc_like  = (code == 1);
        deep      = (code == 2) || (code == 3);
        live_jtag = fuse_jtag_en && !sw_jtag_off;
        if (rst) begin
            e_acmp = 0; e_bod = 0; e_vref = 0; e_wdt = 0; e_mclk = 1; e_jtag = 0;
            e_buf = '1;
            t_acmp = "R1"; t_vref = "R1"; t_mclk = "R1"; t_buf = "R1";
            return;
        end
        e_bod  = fuse_bod_en;
        e_wdt  = sw_wdt_en;
        e_jtag = live_jtag;
        if (!sleep_req) begin
            e_acmp = sw_acmp_en;
            e_vref = fuse_bod_en || (sw_acmp_en && acmp_use_ref) || sw_adc_en;
            e_mclk = 1;
            e_buf  = '1;
            t_acmp = "R12"; t_mclk = "R12"; t_buf = "R12"; t_vref = "R4";
        end else begin
            e_acmp = (idle_like || adc_like) ? sw_acmp_en : 1'b0;
            e_vref = fuse_bod_en || (sw_acmp_en && acmp_use_ref) ||
                     (sw_adc_en && (idle_like || adc_like));
            e_mclk = deep ? (fuse_ocd_en && live_jtag) : 1'b1;
            e_buf  = (idle_like || adc_like) ? {NP{1'b1}} : wake_pin_mask;
            t_acmp = (code == 4 || code == 5) ? "R2" : "R3";
            t_vref = (sw_acmp_en && acmp_use_ref && !(idle_like || adc_like)) ? "R5" : "R4";
            t_mclk = "R9";
            t_buf  = (code == 4 || code == 5) ? "R2" : "R8";
        end
    endtask

    task automatic compare_all();
        chk(t_acmp, 32'(acmp_en), 32'(e_acmp));
        chk("R6", 32'(bod_en), 32'(e_bod));
        chk(t_vref, 32'(vref_en), 32'(e_vref));
        chk("R7", 32'(wdt_en), 32'(e_wdt));
        chk(t_mclk, 32'(main_clk_en), 32'(e_mclk));
        chk("R10", 32'(jtag_en), 32'(e_jtag));
        chk(t_buf, 32'(inbuf_en), 32'(e_buf));
    endtask

    // One cycle: inputs are applied at the falling edge, sampled at the
    // next rising edge, and the outputs are compared at the falling edge after.
    task automatic step(input logic [10:0] ctl, input logic [NP-1:0] mask);
        @(negedge clk);
        compare_all();
        {sleep_req, sleep_mode, fuse_bod_en, fuse_ocd_en, fuse_jtag_en,
         sw_jtag_off, sw_acmp_en, sw_adc_en, sw_wdt_en} = ctl;
        acmp_use_ref  = ctl[0] ^ ctl[5];
        wake_pin_mask = mask;
        predict();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        predict();
        repeat (3) @(negedge clk);
        // R1: reset state held while rst is high
        compare_all();
        @(negedge clk);
        rst = 0;
        predict();
        // R1: the first sample after reset still shows the reset values
        chk("R1", 32'(main_clk_en), 32'd1);
        chk("R1", 32'(inbuf_en), {32-NP{1'b0}} | {NP{1'b1}});

        // Directed sweep: every mode code, awake and asleep, every fuse/enable pattern.
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 8; m++)
                for (int b = 0; b < 128; b++)
                    step({s[0], m[2:0], b[6:0]}, NP'(12'ha5c ^ (b * 37)));

        // R11: comparator on while awake, then enter Power-down.
        step(11'b0_000_0000100, '0);
        step(11'b0_000_0000100, '0);
        @(negedge clk);
        compare_all();
        sleep_req = 1; sleep_mode = 3'b010;
        #1;
        chk("R11", 32'(acmp_en), 32'd1);      // not yet through the register
        predict();
        @(negedge clk);
        chk("R11", 32'(acmp_en), 32'd0);      // one clock later
        chk("R11", 32'(inbuf_en), 32'd0);
        sleep_req = 0;
        #1;
        chk("R11", 32'(inbuf_en), 32'd0);
        predict();
        @(negedge clk);
        chk("R11", 32'(inbuf_en), {32-NP{1'b0}} | {NP{1'b1}});
        chk("R11", 32'(acmp_en), 32'd1);

        // R5: comparator with internal reference in Power-save, ADC and BOD off.
        step(11'b1_011_0000100, '0);   // acmp_use_ref = ctl[0]^ctl[5] = 0
        step(11'b1_011_0000101, '0);   // use_ref=1 but wdt on
        step(11'b1_011_0100100, '0);   // use_ref via ctl[5]
        step(11'b1_011_0000000, '0);

        // Random run with mode changes on consecutive clocks.
        for (int i = 0; i < 4000; i++)
            step(11'($urandom), NP'($urandom));

        @(negedge clk);
        compare_all();
        summary();
        $finish;
    end
endmodule